// File: doc/BRIEF.md
# Dual multi-mode timer/counter

This block holds two timer/counters, each stored as a low count byte and a high count byte. A machine-cycle enable pulse drives them. A two-bit mode field for each timer picks one of four behaviours:
- a 13-bit counter whose low byte acts as a 5-bit prescaler,
- a full 16-bit counter,
- an 8-bit counter that reloads itself from the high byte,
- a split mode. In split mode timer 0 becomes two independent 8-bit counters and timer 1 is frozen.

A control register holds a run bit and an overflow flag for each timer. The flags drive two interrupt request outputs.

Software reaches every register through one write port and one combinational read port. Each timer has a gate enable and an external pin. When the gate enable is set, the timer counts only while its pin is high. A flag is set by hardware when its counter wraps. A software write to the control register can set or clear it, and an interrupt acknowledge clears it.

Top module: `dual_timer_unit`

## Requirements
- R1: Mode 00 (a timer's mode field = 2'b00) counts the 13-bit value {high byte, low byte[4:0]}. Bits 7:5 of the low byte always read 0 after a count or a write in this mode. The step from 0x1FFF wraps to 0 and sets the timer's flag.
- R2: Mode 01 counts the 16-bit value {high, low}. The step from 0xFFFF wraps to 0 and sets the timer's flag.
- R3: Mode 10 increments the low byte. On the step from 0xFF the low byte is loaded with the high byte, which stays unchanged, and the timer's flag is set.
- R4: Mode 11 on timer 0 splits it in two. The low byte counts under run bit 0 and gate 0 and sets flag 0 when it wraps. The high byte counts under run bit 1 alone and sets flag 1 when it wraps. While timer 0 is split, a wrap of timer 1 never sets flag 1.
- R5: Mode 11 on timer 1 freezes both of its bytes even when run bit 1 is set.
- R6: A timer counts only on a cycle where the tick input is high and its run bit is 1. Otherwise its count holds.
- R7: When a timer's gate enable is 1, it counts only while its external pin is 1.
- R8: Writing the control register loads both flags from bits 7 and 5. A pulse on int_ack[i] clears flag i. irq_req[i] shows flag i.
- R9: A hardware flag set beats an acknowledge or a control write in the same cycle.
- R10: A write to a count byte is readable on the next cycle. In the cycle of the write, that timer does not increment, so the written value stands unchanged.
- R11: After reset every register reads 0 and both interrupt requests are low.
- R12: The register map is as follows. Address 0 is control: bit 7 is flag 1, bit 6 is run 1, bit 5 is flag 0, bit 4 is run 0, and bits 3:0 are plain storage. Address 1 is modes: bits 1:0 for timer 0, bits 3:2 for timer 1. Addresses 2/3 are timer 0 low/high. Addresses 4/5 are timer 1 low/high. Each address reads back what was written, except where R1 masks the value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| tick | input | 1 | Machine-cycle count enable |
| gate_en | input | 2 | Per-timer gate enable |
| ext_pin | input | 2 | Per-timer external pin level |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | BYTE_W | Write data |
| rd_addr | input | 3 | Read address |
| rd_data | output | BYTE_W | Read data, combinational |
| int_ack | input | 2 | Per-flag interrupt acknowledge |
| irq_req | output | 2 | Overflow flags as interrupt requests |

## Verification
The bench builds the block with BYTE_W = 8 and PRE_W = 5. With these defaults every wrap point (0x1FFF, 0xFFFF, 0xFF) can be reached within one to three ticks: the count bytes are preloaded just below the wrap. The same defaults make the three masked bits of the prescaled low byte visible when a value such as 0xE3 is written in mode 00.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
   typedef enum logic [1:0] {
      TM_PRESC  = 2'b00,
      TM_WIDE   = 2'b01,
      TM_RELOAD = 2'b10,
      TM_SPLIT  = 2'b11
   } tmr_mode_e;

   localparam int unsigned ADDR_W = 3;
   localparam logic [ADDR_W-1:0] A_CTRL = 3'd0;
   localparam logic [ADDR_W-1:0] A_MODE = 3'd1;
   localparam logic [ADDR_W-1:0] A_T0L  = 3'd2;
   localparam logic [ADDR_W-1:0] A_T0H  = 3'd3;
   localparam logic [ADDR_W-1:0] A_T1L  = 3'd4;
   localparam logic [ADDR_W-1:0] A_T1H  = 3'd5;
endpackage

// File: rtl/flag_cell.sv
module flag_cell (
   input  logic clk,
   input  logic rst_n,
   input  logic hw_set,
   input  logic sw_wr,
   input  logic sw_val,
   input  logic ack,
   output logic q
);
   logic q_n;

   always_comb begin
      q_n = q;
      if (ack)    q_n = 1'b0;
      if (sw_wr)  q_n = sw_val;
      if (hw_set) q_n = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= 1'b0;
      else        q <= q_n;
   end

   assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
      hw_set |=> q);

   assert_ack_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (ack && !hw_set && !sw_wr) |=> !q);
endmodule

// File: rtl/timer_core.sv
module timer_core
   import tmr_pkg::*;
#(
   parameter int unsigned BYTE_W   = 8,
   parameter int unsigned PRE_W    = 5,
   parameter bit          SPLIT_OK = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              run_main,
   input  logic              run_aux,
   input  tmr_mode_e         mode,
   input  logic              wr_lo,
   input  logic              wr_hi,
   input  logic [BYTE_W-1:0] wr_data,
   output logic [BYTE_W-1:0] cnt_lo,
   output logic [BYTE_W-1:0] cnt_hi,
   output logic              wrap_main,
   output logic              wrap_aux
);
   localparam int unsigned PW = BYTE_W + PRE_W;
   localparam int unsigned FW = 2 * BYTE_W;
   localparam int unsigned ZW = BYTE_W - PRE_W;

   if (PRE_W == 0 || PRE_W >= BYTE_W) begin : g_bad_presc
      $error("timer_core: PRE_W must lie in 1..BYTE_W-1");
   end

   logic              hold, step_main, step_aux;
   logic [PW-1:0]     pre_cnt, pre_inc;
   logic [FW-1:0]     wide_cnt, wide_inc;
   logic [BYTE_W-1:0] lo_inc, lo_n, hi_n;
   logic [BYTE_W-1:0] sp_lo_n, sp_hi_n;
   logic              sp_lo_wrap, sp_hi_wrap;
   logic [BYTE_W-1:0] wr_masked;

   assign hold      = wr_lo | wr_hi;
   assign step_main = tick & run_main & ~hold;
   assign step_aux  = tick & run_aux & ~hold;
   assign pre_cnt   = {cnt_hi, cnt_lo[PRE_W-1:0]};
   assign pre_inc   = pre_cnt + 1'b1;
   assign wide_cnt  = {cnt_hi, cnt_lo};
   assign wide_inc  = wide_cnt + 1'b1;
   assign lo_inc    = cnt_lo + 1'b1;
   assign wr_masked = {{ZW{1'b0}}, wr_data[PRE_W-1:0]};

   if (SPLIT_OK) begin : g_split
      assign sp_lo_n    = step_main ? lo_inc : cnt_lo;
      assign sp_lo_wrap = step_main & (&cnt_lo);
      assign sp_hi_n    = step_aux ? (cnt_hi + 1'b1) : cnt_hi;
      assign sp_hi_wrap = step_aux & (&cnt_hi);
   end else begin : g_frozen
      assign sp_lo_n    = cnt_lo;
      assign sp_lo_wrap = 1'b0;
      assign sp_hi_n    = cnt_hi;
      assign sp_hi_wrap = 1'b0;
   end

   always_comb begin
      lo_n      = cnt_lo;
      hi_n      = cnt_hi;
      wrap_main = 1'b0;
      wrap_aux  = 1'b0;
      case (mode)
         TM_PRESC: if (step_main) begin
            lo_n      = {{ZW{1'b0}}, pre_inc[PRE_W-1:0]};
            hi_n      = pre_inc[PW-1:PRE_W];
            wrap_main = &pre_cnt;
         end
         TM_WIDE: if (step_main) begin
            {hi_n, lo_n} = wide_inc;
            wrap_main    = &wide_cnt;
         end
         TM_RELOAD: if (step_main) begin
            lo_n      = (&cnt_lo) ? cnt_hi : lo_inc;
            wrap_main = &cnt_lo;
         end
         default: begin
            lo_n      = sp_lo_n;
            hi_n      = sp_hi_n;
            wrap_main = sp_lo_wrap;
            wrap_aux  = sp_hi_wrap;
         end
      endcase
      if (wr_lo) lo_n = (mode == TM_PRESC) ? wr_masked : wr_data;
      if (wr_hi) hi_n = wr_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_lo <= '0;
         cnt_hi <= '0;
      end else begin
         cnt_lo <= lo_n;
         cnt_hi <= hi_n;
      end
   end

   assert_presc_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == TM_PRESC && (step_main || wr_lo)) |=> (cnt_lo[BYTE_W-1:PRE_W] == '0));

   assert_reload_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == TM_RELOAD && step_main && (&cnt_lo)) |=> (cnt_lo == $past(cnt_hi)));

   assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!step_main && !step_aux && !hold) |=> ($stable(cnt_lo) && $stable(cnt_hi)));
endmodule

// File: rtl/dual_timer_unit.sv
module dual_timer_unit
   import tmr_pkg::*;
#(
   parameter int unsigned BYTE_W = 8,
   parameter int unsigned PRE_W  = 5
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    tick,
   input  logic [1:0]              gate_en,
   input  logic [1:0]              ext_pin,
   input  logic                    wr_en,
   input  logic [ADDR_W-1:0]       wr_addr,
   input  logic [BYTE_W-1:0]       wr_data,
   input  logic [ADDR_W-1:0]       rd_addr,
   output logic [BYTE_W-1:0]       rd_data,
   input  logic [1:0]              int_ack,
   output logic [1:0]              irq_req
);
   localparam int unsigned N_TMR = 2;

   if (BYTE_W < 8) begin : g_bad_width
      $error("dual_timer_unit: BYTE_W must be at least 8");
   end

   logic [3:0]        ctrl_spare;
   logic [N_TMR-1:0]  run_q, flag_q, flag_set;
   tmr_mode_e         mode_q [N_TMR];
   logic [BYTE_W-1:0] lo_q [N_TMR];
   logic [BYTE_W-1:0] hi_q [N_TMR];
   logic [N_TMR-1:0]  wrap_main, wrap_aux, tw_lo, tw_hi;
   logic              wr_ctrl, wr_mode, split0;

   assign wr_ctrl = wr_en && (wr_addr == A_CTRL);
   assign wr_mode = wr_en && (wr_addr == A_MODE);
   assign split0  = (mode_q[0] == TM_SPLIT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_spare <= '0;
         run_q      <= '0;
         mode_q[0]  <= TM_PRESC;
         mode_q[1]  <= TM_PRESC;
      end else begin
         if (wr_ctrl) begin
            ctrl_spare <= wr_data[3:0];
            run_q      <= {wr_data[6], wr_data[4]};
         end
         if (wr_mode) begin
            mode_q[0] <= tmr_mode_e'(wr_data[1:0]);
            mode_q[1] <= tmr_mode_e'(wr_data[3:2]);
         end
      end
   end

   for (genvar i = 0; i < N_TMR; i++) begin : g_tmr
      localparam logic [ADDR_W-1:0] LO_A = (i == 0) ? A_T0L : A_T1L;
      localparam logic [ADDR_W-1:0] HI_A = (i == 0) ? A_T0H : A_T1H;

      assign tw_lo[i] = wr_en && (wr_addr == LO_A);
      assign tw_hi[i] = wr_en && (wr_addr == HI_A);

      timer_core #(
         .BYTE_W   (BYTE_W),
         .PRE_W    (PRE_W),
         .SPLIT_OK (i == 0)
      ) u_core (
         .clk       (clk),
         .rst_n     (rst_n),
         .tick      (tick),
         .run_main  (run_q[i] & (~gate_en[i] | ext_pin[i])),
         .run_aux   (run_q[1]),
         .mode      (mode_q[i]),
         .wr_lo     (tw_lo[i]),
         .wr_hi     (tw_hi[i]),
         .wr_data   (wr_data),
         .cnt_lo    (lo_q[i]),
         .cnt_hi    (hi_q[i]),
         .wrap_main (wrap_main[i]),
         .wrap_aux  (wrap_aux[i])
      );
   end

   assign flag_set[0] = wrap_main[0];
   assign flag_set[1] = split0 ? wrap_aux[0] : (wrap_main[1] | wrap_aux[1]);

   for (genvar i = 0; i < N_TMR; i++) begin : g_flag
      localparam int unsigned FB = (i == 0) ? 5 : 7;
      flag_cell u_flag (
         .clk    (clk),
         .rst_n  (rst_n),
         .hw_set (flag_set[i]),
         .sw_wr  (wr_ctrl),
         .sw_val (wr_data[FB]),
         .ack    (int_ack[i]),
         .q      (flag_q[i])
      );
   end

   assign irq_req = flag_q;

   always_comb begin
      rd_data = '0;
      case (rd_addr)
         A_CTRL: rd_data[7:0] = {flag_q[1], run_q[1], flag_q[0], run_q[0], ctrl_spare};
         A_MODE: rd_data[3:0] = {mode_q[1], mode_q[0]};
         A_T0L:  rd_data = lo_q[0];
         A_T0H:  rd_data = hi_q[0];
         A_T1L:  rd_data = lo_q[1];
         A_T1H:  rd_data = hi_q[1];
         default: rd_data = '0;
      endcase
   end

   assert_t1_frozen_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q[1] == TM_SPLIT && !tw_lo[1] && !tw_hi[1]) |=> ($stable(lo_q[1]) && $stable(hi_q[1])));

   assert_split_tf1_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (split0 && !wrap_aux[0] && !wr_ctrl && !flag_q[1]) |=> !flag_q[1]);
endmodule

// File: tb/dual_timer_unit_bench.sv
`timescale 1ns/1ps
module dual_timer_unit_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick = 1'b0;
   logic [1:0] gate_en = '0, ext_pin = '0, int_ack = '0;
   logic       wr_en = 1'b0;
   logic [2:0] wr_addr = '0, rd_addr = '0;
   logic [7:0] wr_data = '0;
   logic [7:0] rd_data;
   logic [1:0] irq_req;
   int checks = 0;
   int failures = 0;

   always #2 clk = ~clk;

   dual_timer_unit u_dual_timer_unit (
      .clk(clk), .rst_n(rst_n), .tick(tick), .gate_en(gate_en), .ext_pin(ext_pin),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
      .rd_data(rd_data), .int_ack(int_ack), .irq_req(irq_req)
   );

   typedef struct packed {
      logic [7:0] req, mode, ctrl, hi, lo, n, ehi, elo, eflag;
   } vec_t;

   localparam int NV = 11;
   localparam vec_t VEC [NV] = '{
      '{8'd1, 8'h0C, 8'h10, 8'hFF, 8'h1E, 8'd1, 8'hFF, 8'h1F, 8'h00}, // R1 just below wrap
      '{8'd1, 8'h0C, 8'h10, 8'hFF, 8'h1E, 8'd2, 8'h00, 8'h00, 8'h20}, // R1 wrap at 0x1FFF
      '{8'd1, 8'h0C, 8'h10, 8'h00, 8'h1F, 8'd1, 8'h01, 8'h00, 8'h00}, // R1 prescale carry
      '{8'd1, 8'h0C, 8'h10, 8'h12, 8'hE3, 8'd0, 8'h12, 8'h03, 8'h00}, // R1 masked write
      '{8'd2, 8'h0D, 8'h10, 8'hFF, 8'hFE, 8'd2, 8'h00, 8'h00, 8'h20}, // R2 wrap
      '{8'd2, 8'h0D, 8'h10, 8'h00, 8'hFF, 8'd1, 8'h01, 8'h00, 8'h00}, // R2 byte carry
      '{8'd3, 8'h0E, 8'h10, 8'h80, 8'hFE, 8'd2, 8'h80, 8'h80, 8'h20}, // R3 reload
      '{8'd3, 8'h0E, 8'h10, 8'h80, 8'hFE, 8'd3, 8'h80, 8'h81, 8'h20}, // R3 after reload
      '{8'd4, 8'h0F, 8'h10, 8'h10, 8'hFF, 8'd1, 8'h10, 8'h00, 8'h20}, // R4 low half only
      '{8'd4, 8'h0F, 8'h50, 8'hFF, 8'hFF, 8'd1, 8'h00, 8'h00, 8'hA0}, // R4 both halves
      '{8'd6, 8'h0D, 8'h00, 8'h34, 8'h12, 8'd5, 8'h34, 8'h12, 8'h00}  // R6 run bit clear
   };

   task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [7:0] d);
      rd_addr = a;
      #0.5;
      d = rd_data;
   endtask

   task automatic ticks(input int n);
      @(negedge clk);
      tick = 1'b1;
      repeat (n) @(negedge clk);
      tick = 1'b0;
   endtask

   task automatic finish_run();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      failures++;
      $display("FAIL watchdog act=running exp=done");
      finish_run();
   end

   initial begin
      logic [7:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R11 reset state
      for (int a = 0; a < 6; a++) begin
         rd(3'(a), v);
         check("R11 reset reg", v, 8'h00);
      end
      check("R11 reset irq", {6'd0, irq_req}, 8'h00);

      // table walk
      for (int i = 0; i < NV; i++) begin
         string tag;
         tag = $sformatf("R%0d vec%0d", VEC[i].req, i);
         wr(3'd0, 8'h00);
         wr(3'd1, VEC[i].mode);
         wr(3'd2, VEC[i].lo);
         wr(3'd3, VEC[i].hi);
         wr(3'd0, VEC[i].ctrl);
         if (VEC[i].n != 0) ticks(int'(VEC[i].n));
         @(negedge clk);
         rd(3'd2, v); check({tag, " lo"}, v, VEC[i].elo);
         rd(3'd3, v); check({tag, " hi"}, v, VEC[i].ehi);
         rd(3'd0, v); check({tag, " flags"}, v & 8'hA0, VEC[i].eflag);
         wr(3'd0, 8'h00);
      end

      // R5 timer 1 frozen in mode 11, runs in mode 01
      wr(3'd1, 8'h0D); wr(3'd4, 8'h05); wr(3'd5, 8'h00); wr(3'd0, 8'h40);
      ticks(4); @(negedge clk);
      rd(3'd4, v); check("R5 t1 frozen", v, 8'h05);
      wr(3'd1, 8'h05);
      ticks(4); @(negedge clk);
      rd(3'd4, v); check("R5 t1 runs in mode 01", v, 8'h09);
      wr(3'd0, 8'h00);

      // R4 timer 1 wrap does not set flag 1 while timer 0 is split
      wr(3'd1, 8'h07); wr(3'd2, 8'h00); wr(3'd3, 8'h00);
      wr(3'd4, 8'hFF); wr(3'd5, 8'hFF); wr(3'd0, 8'h40);
      ticks(1); @(negedge clk);
      rd(3'd4, v); check("R4 t1 wrapped", v, 8'h00);
      rd(3'd3, v); check("R4 t0 high under run 1", v, 8'h01);
      rd(3'd2, v); check("R4 t0 low idle", v, 8'h00);
      rd(3'd0, v); check("R4 no flag from t1", v & 8'hA0, 8'h00);
      wr(3'd0, 8'h00);

      // R7 gate
      wr(3'd1, 8'h0D); wr(3'd2, 8'h00); wr(3'd3, 8'h00); wr(3'd0, 8'h10);
      gate_en = 2'b01; ext_pin = 2'b00;
      ticks(3); @(negedge clk);
      rd(3'd2, v); check("R7 gated pin low", v, 8'h00);
      ext_pin = 2'b01;
      ticks(3); @(negedge clk);
      rd(3'd2, v); check("R7 gated pin high", v, 8'h03);
      gate_en = 2'b00; ext_pin = 2'b00;

      // R10 write suppresses that cycle's increment
      @(negedge clk);
      tick = 1'b1; wr_en = 1'b1; wr_addr = 3'd2; wr_data = 8'h40;
      @(negedge clk);
      wr_en = 1'b0;
      rd(3'd2, v); check("R10 written value stands", v, 8'h40);
      @(negedge clk);
      tick = 1'b0;
      rd(3'd2, v); check("R10 counting resumes", v, 8'h41);
      wr(3'd0, 8'h00);

      // R9 set beats acknowledge
      wr(3'd1, 8'h0E); wr(3'd3, 8'h00); wr(3'd2, 8'hFF); wr(3'd0, 8'h10);
      @(negedge clk);
      tick = 1'b1; int_ack = 2'b01;
      @(negedge clk);
      tick = 1'b0; int_ack = 2'b00;
      check("R9 flag set over ack", {7'd0, irq_req[0]}, 8'h01);
      rd(3'd2, v); check("R3 reload to zero", v, 8'h00);

      // R8 acknowledge and software access
      @(negedge clk); int_ack = 2'b01;
      @(negedge clk); int_ack = 2'b00;
      check("R8 ack clears flag 0", {7'd0, irq_req[0]}, 8'h00);
      wr(3'd0, 8'h20);
      check("R8 sw sets flag 0", {7'd0, irq_req[0]}, 8'h01);
      wr(3'd0, 8'h00);
      check("R8 sw clears flag 0", {7'd0, irq_req[0]}, 8'h00);
      wr(3'd0, 8'h80);
      check("R8 sw sets flag 1", {7'd0, irq_req[1]}, 8'h01);
      @(negedge clk); int_ack = 2'b10;
      @(negedge clk); int_ack = 2'b00;
      check("R8 ack clears flag 1", {7'd0, irq_req[1]}, 8'h00);

      // R12 register map readback
      wr(3'd1, 8'h0E);
      rd(3'd1, v); check("R12 mode readback", v, 8'h0E);
      wr(3'd0, 8'h5A);
      rd(3'd0, v); check("R12 ctrl readback", v, 8'h5A);
      wr(3'd0, 8'h00);

      finish_run();
   end
endmodule